// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate Unit

The unit holds a signed accumulator of twice the operand width, presented as a high half and a low half. On each start strobe it multiplies two signed operands and adds the product to the accumulator. A mode input picks the operand width. Long mode multiplies the full operands. Word mode multiplies only the narrow low fields of the operands, sign-extended. A clear command empties the accumulator. A saturation enable bounds the result, and the rule it applies depends on the mode.

Control is a two-state machine. `ST_IDLE` means no result is pending and `done` is low. `ST_DONE` means an accumulation was registered at the previous edge and `done` is high. The transitions are the same from either state:
- clear goes to `ST_IDLE` and wins over start;
- start without clear goes to `ST_DONE`;
- no request goes to `ST_IDLE`.

Back-to-back starts therefore keep the machine in `ST_DONE`. The next accumulator value is formed in three steps: a product stage (`mac_prod`), a wrapping adder, and a clamp stage (`mac_sat`). It is registered at the edge that samples start.

Top module: `sat_mac`

## Requirements
- R1: A synchronous reset sets both accumulator halves to zero and drives `done` low.
- R2: With `mode_word`=0 and `sat_en`=0, a start adds the signed product of the two full DW-bit operands to the signed accumulator {acc_hi, acc_lo}. The sum wraps modulo 2^(2*DW).
- R3: With `mode_word`=1 and `sat_en`=0, only operand bits [HW-1:0] are used, each as a signed value. Bits [DW-1:HW] have no effect on the result. The wrapped sum is stored.
- R4: In long mode with `sat_en`=1, a sum whose bit 2*DW-1 is 1 is stored with acc_hi bits [DW-1:HW] forced to ones. All other bits keep the sum.
- R5: In long mode with `sat_en`=1, a sum whose bit 2*DW-1 is 0 is stored with acc_hi ANDed with 2^(HW-1)-1. acc_lo keeps the sum.
- R6: In word mode with `sat_en`=1, a signed sum below -2^(DW-1) stores acc_hi=1 and acc_lo=2^(DW-1) (only the top bit set).
- R7: In word mode with `sat_en`=1, a signed sum above 2^(DW-1)-1 stores acc_hi=1 and acc_lo=2^(DW-1)-1.
- R8: In word mode with `sat_en`=1, a sum within the signed DW-bit range is stored unchanged at full width.
- R9: `clear` zeroes both halves at the next edge. It takes priority over `start` in the same cycle, and that cycle produces no `done`.
- R10: `done` is high exactly in the cycle after an edge that sampled start without clear. The accumulator holds its value in any cycle with neither start nor clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Accumulate request, sampled each edge |
| clear | input | 1 | Zero the accumulator; wins over start |
| mode_word | input | 1 | 0: long mode, full operands; 1: word mode, low HW bits |
| sat_en | input | 1 | Enable mode-dependent clamping |
| op_a | input | DW | First signed operand |
| op_b | input | DW | Second signed operand |
| acc_hi | output | DW | Upper half of the accumulator |
| acc_lo | output | DW | Lower half of the accumulator |
| done | output | 1 | One-cycle result pulse, held high across back-to-back starts |

## Verification
The bench builds the unit with DW=8 and HW=4, which makes the accumulator 16 bits wide. At this size every pair of word-mode nibbles can be swept with saturation both off and on. Chained accumulation drives the 16-bit sum across the signed 8-bit limits often, so the two word-mode flag cases and the in-range case all occur many times. In long mode the sweep takes every value of the first operand against a strided set of second operands. Sign flips of the small accumulator reach both long-mode clamp rules and wraparound in a few thousand cycles.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } mac_state_e;
endpackage

// File: rtl/mac_prod.sv
module mac_prod #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            word,
    output logic [2*DW-1:0] prod
);
    localparam int AW = 2 * DW;

    logic [AW-1:0] ext_a;
    logic [AW-1:0] ext_b;

    // Sign-extend to accumulator width; the low AW bits of the unsigned
    // product equal the signed product modulo 2^AW.
    always_comb begin
        if (word) begin
            ext_a = {{(AW-HW){a[HW-1]}}, a[HW-1:0]};
            ext_b = {{(AW-HW){b[HW-1]}}, b[HW-1:0]};
        end else begin
            ext_a = {{DW{a[DW-1]}}, a};
            ext_b = {{DW{b[DW-1]}}, b};
        end
        prod = ext_a * ext_b;
    end
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic [2*DW-1:0] sum,
    input  logic            word,
    input  logic            sat,
    output logic [DW-1:0]   hi,
    output logic [DW-1:0]   lo
);
    localparam int AW = 2 * DW;
    localparam logic [DW-1:0] FILL_NEG = {{(DW-HW){1'b1}}, {HW{1'b0}}};
    localparam logic [DW-1:0] KEEP_POS = {{(DW-HW+1){1'b0}}, {(HW-1){1'b1}}};
    localparam logic [DW-1:0] LIM_MIN  = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] LIM_MAX  = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] FLAG     = {{(DW-1){1'b0}}, 1'b1};

    logic neg;
    logic out_of_range;

    assign neg          = sum[AW-1];
    // In range of a signed DW-bit value iff bits [AW-1:DW-1] all agree.
    assign out_of_range = !((&sum[AW-1:DW-1]) || !(|sum[AW-1:DW-1]));

    always_comb begin
        hi = sum[AW-1:DW];
        lo = sum[DW-1:0];
        if (sat) begin
            if (!word) begin
                hi = neg ? (sum[AW-1:DW] | FILL_NEG) : (sum[AW-1:DW] & KEEP_POS);
            end else if (out_of_range) begin
                hi = FLAG;
                lo = neg ? LIM_MIN : LIM_MAX;
            end
        end
    end
endmodule

// File: rtl/sat_mac.sv
module sat_mac
    import mac_pkg::*;
#(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          clear,
    input  logic          mode_word,
    input  logic          sat_en,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [DW-1:0] acc_hi,
    output logic [DW-1:0] acc_lo,
    output logic          done
);
    localparam int AW = 2 * DW;

    mac_state_e    state_q;
    mac_state_e    state_d;
    logic [AW-1:0] acc_q;
    logic [AW-1:0] prod;
    logic [AW-1:0] sum;
    logic [DW-1:0] nxt_hi;
    logic [DW-1:0] nxt_lo;

    mac_prod #(.DW(DW), .HW(HW)) u_prod (
        .a    (op_a),
        .b    (op_b),
        .word (mode_word),
        .prod (prod)
    );

    assign sum = acc_q + prod;

    mac_sat #(.DW(DW), .HW(HW)) u_sat (
        .sum  (sum),
        .word (mode_word),
        .sat  (sat_en),
        .hi   (nxt_hi),
        .lo   (nxt_lo)
    );

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (clear)      state_d = ST_IDLE;
                else if (start) state_d = ST_DONE;
                else            state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) acc_q <= '0;
        else if (start)   acc_q <= {nxt_hi, nxt_lo};
    end

    always_comb begin
        done   = (state_q == ST_DONE);
        acc_hi = acc_q[AW-1:DW];
        acc_lo = acc_q[DW-1:0];
    end
endmodule

// File: rtl/mac_chk.sv
module mac_chk #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          clear,
    input logic          mode_word,
    input logic          sat_en,
    input logic [DW-1:0] acc_hi,
    input logic [DW-1:0] acc_lo,
    input logic          done
);
    localparam logic [DW-1:0] ONE     = {{(DW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] LIM_MIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] LIM_MAX = {1'b0, {(DW-1){1'b1}}};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!done && acc_hi == '0 && acc_lo == '0)); // R1

    AST_LONG_NEG_FILL: assert property (@(posedge clk) disable iff (rst)
        (start && !clear && !mode_word && sat_en)
        |=> (!acc_hi[DW-1] || (&acc_hi[DW-1:HW]))); // R4

    AST_LONG_POS_MASK: assert property (@(posedge clk) disable iff (rst)
        (start && !clear && !mode_word && sat_en)
        |=> (acc_hi[DW-1] || (acc_hi[DW-1:HW-1] == '0))); // R5

    AST_WORD_FLAG_NEG: assert property (@(posedge clk) disable iff (rst)
        (start && !clear && mode_word && sat_en)
        |=> (acc_hi != ONE || !acc_lo[DW-1] || acc_lo == LIM_MIN)); // R6

    AST_WORD_FLAG_POS: assert property (@(posedge clk) disable iff (rst)
        (start && !clear && mode_word && sat_en)
        |=> (acc_hi != ONE || acc_lo[DW-1] || acc_lo == LIM_MAX)); // R7

    AST_WORD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (start && !clear && mode_word && sat_en)
        |=> (acc_hi == ONE || acc_hi == {DW{acc_lo[DW-1]}})); // R8

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc_hi == '0 && acc_lo == '0 && !done)); // R9

    AST_DONE_RISE: assert property (@(posedge clk) disable iff (rst)
        (start && !clear) |=> done); // R10

    AST_DONE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!start && !clear) |=> (!done && $stable(acc_hi) && $stable(acc_lo))); // R10
endmodule

bind sat_mac mac_chk #(.DW(DW), .HW(HW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .clear     (clear),
    .mode_word (mode_word),
    .sat_en    (sat_en),
    .acc_hi    (acc_hi),
    .acc_lo    (acc_lo),
    .done      (done)
);

// File: tb/sim_sat_mac.sv
`timescale 1ns/1ps
module sim_sat_mac;
    localparam int DW = 8;
    localparam int HW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          clear = 1'b0;
    logic          mode_word = 1'b0;
    logic          sat_en = 1'b0;
    logic [DW-1:0] op_a = '0;
    logic [DW-1:0] op_b = '0;
    logic [DW-1:0] acc_hi;
    logic [DW-1:0] acc_lo;
    logic          done;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   finished = 1'b0;
    logic [15:0] exp_acc = '0;

    always #10 clk = ~clk;

    sat_mac #(.DW(DW), .HW(HW)) u0 (
        .clk(clk), .rst(rst), .start(start), .clear(clear),
        .mode_word(mode_word), .sat_en(sat_en), .op_a(op_a), .op_b(op_b),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model: returns next accumulator and the requirement it exercises.
    function automatic logic [15:0] model(input logic [15:0] acc, input logic [7:0] a,
                                          input logic [7:0] b, input bit w, input bit s,
                                          output string tag);
        int pa, pb, total, rs;
        logic [31:0] tw;
        logic [15:0] r;
        pa = w ? int'($signed(a[3:0])) : int'($signed(a));
        pb = w ? int'($signed(b[3:0])) : int'($signed(b));
        total = int'($signed(acc)) + pa * pb;
        tw = total;
        r = tw[15:0];
        tag = w ? "R3" : "R2";
        if (s && !w) begin
            if (r[15]) begin r[15:12] = 4'hF; tag = "R4"; end
            else begin r[15:8] = r[15:8] & 8'h07; tag = "R5"; end
        end else if (s && w) begin
            rs = int'($signed(r));
            if (rs < -128)     begin r = 16'h0180; tag = "R6"; end
            else if (rs > 127) begin r = 16'h017F; tag = "R7"; end
            else               tag = "R8";
        end
        return r;
    endfunction

    // Called at a negedge; returns at the following negedge after the update.
    task automatic run_op(input logic [7:0] a, input logic [7:0] b, input bit w, input bit s);
        string tag;
        logic [15:0] e;
        op_a = a; op_b = b; mode_word = w; sat_en = s; start = 1'b1; clear = 1'b0;
        e = model(exp_acc, a, b, w, s, tag);
        @(negedge clk);
        chk({acc_hi, acc_lo} == e, tag, {16'h0, acc_hi, acc_lo}, {16'h0, e});
        chk(done == 1'b1, "R10", {31'h0, done}, 32'h1);
        exp_acc = e;
    endtask

    task automatic go_idle();
        start = 1'b0; clear = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R10", {31'h0, done}, 32'h0);
        chk({acc_hi, acc_lo} == exp_acc, "R10", {16'h0, acc_hi, acc_lo}, {16'h0, exp_acc});
    endtask

    task automatic do_clear(input bit with_start);
        start = with_start; clear = 1'b1;
        op_a = 8'h7F; op_b = 8'h7F; mode_word = 1'b0; sat_en = 1'b0;
        @(negedge clk);
        exp_acc = '0;
        chk({acc_hi, acc_lo} == 16'h0, "R9", {16'h0, acc_hi, acc_lo}, 32'h0);
        chk(done == 1'b0, "R9", {31'h0, done}, 32'h0);
        clear = 1'b0; start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({acc_hi, acc_lo} == 16'h0, "R1", {16'h0, acc_hi, acc_lo}, 32'h0);
        chk(done == 1'b0, "R1", {31'h0, done}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // R2: directed long products, then idle hold
        run_op(8'h80, 8'h80, 1'b0, 1'b0);   // +16384
        run_op(8'h7F, 8'h81, 1'b0, 1'b0);   // -16129
        go_idle();

        // R3: upper operand bits ignored in word mode
        do_clear(1'b0);
        run_op(8'hA3, 8'h5E, 1'b1, 1'b0);   // 3 * -2
        run_op(8'h03, 8'hFE, 1'b1, 1'b0);
        go_idle();

        // R7 then R6, directed word saturation
        do_clear(1'b0);
        repeat (3) run_op(8'h07, 8'h07, 1'b1, 1'b1);
        do_clear(1'b0);
        repeat (3) run_op(8'h08, 8'h07, 1'b1, 1'b1);
        go_idle();

        // R9: clear wins over start
        run_op(8'h11, 8'h22, 1'b0, 1'b0);
        do_clear(1'b1);
        go_idle();

        // Word-mode sweep over all nibble pairs, upper bits scrambled
        for (int s = 0; s < 2; s++) begin
            do_clear(1'b0);
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    run_op({4'(x) ^ 4'h5, 4'(x)}, {~4'(y), 4'(y)}, 1'b1, s[0]);
                end
            end
            go_idle();
        end

        // Long-mode sweep: all first operands, strided second operands
        for (int s = 0; s < 2; s++) begin
            do_clear(1'b0);
            for (int i = 0; i < 256; i++) begin
                for (int j = 0; j < 256; j += 7) begin
                    run_op(8'(i), 8'(j), 1'b0, s[0]);
                end
            end
            go_idle();
        end

        // R1: reset during operation
        run_op(8'h40, 8'h40, 1'b0, 1'b0);
        rst = 1'b1; start = 1'b1;
        @(negedge clk);
        chk({acc_hi, acc_lo} == 16'h0, "R1", {16'h0, acc_hi, acc_lo}, 32'h0);
        chk(done == 1'b0, "R1", {31'h0, done}, 32'h0);
        rst = 1'b0; start = 1'b0;

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule